// File: doc/BRIEF.md
# Six-Stage Program Stepper

The stepper is a sequencing controller for pulse-driven programs. It keeps a current stage, one of six, and forwards every incoming program pulse to the output line that belongs to that stage. Each stage has its own pulse-count limit, written as two decimal (BCD) digits. Once a stage has passed that many pulses, the stepper moves on to the next stage. Because stage output lines can drive the pulse input of a second stepper, loops can be nested by chaining steppers.

A direct-select path overrides the counting sequence at once. A decimal digit from 0 to 5 jumps straight to the matching stage, which gives a six-way computed jump. A sign value picks one of two stages, which gives a two-way branch on negative versus non-negative. Two settings decide what happens after the end stage: the stepper either wraps back to the first stage, or it parks on the end stage and keeps routing pulses there without counting.

The control is a two-state machine. In RUN, pulses are counted and stages advance. In HOLD, the stepper is parked and pulses are routed but not counted. Four transitions are named:
- RUN->RUN: a plain advance or a wrap.
- RUN->HOLD: the end-stage count is complete while wrapping is off.
- HOLD->RUN: a clear, or a direct select.
- HOLD->HOLD: a pulse, or an idle cycle, with no select.

Top module: `prog_stepper`

## Requirements
- R1: An active-low reset or a synchronous `clear_i` puts the stepper in RUN on stage index 0, with its counter at zero. `clear_i` takes priority over every other input, and a pulse in the same cycle as `clear_i` produces no output.
- R2: Each `pulse_i` without `clear_i` gives exactly one pulse on `stage_pulse_o`, one cycle later, on bit k, where k is the stage that routed the pulse. With no input pulse, `stage_pulse_o` is zero.
- R3: A stage with limit n passes n pulses and then advances to the next index. The limit of stage k is `limits_i[8k+7:8k]`, with the tens digit in the upper nibble. A limit of 00 behaves as 1.
- R4: The end stage is the stage whose index equals `last_stage_i`, or index 5. When the end stage completes its count and `wrap_i` is 1, the stepper goes to index 0. When `wrap_i` is 0, it enters HOLD: the stage is kept, and later pulses go out on it without advancing.
- R5: `digit_valid_i` with a `digit_i` from 0 to 5 selects stage index `digit_i` at the next edge. It restarts the count and leaves HOLD.
- R6: `digit_valid_i` with a `digit_i` above 5 has no effect, and the current stage is kept.
- R7: `sign_valid_i` selects index 1 when `sign_neg_i` is 1 and index 0 when it is 0. A valid digit from 0 to 5 in the same cycle takes precedence.
- R8: A pulse in the same cycle as a select goes out on the newly selected stage and counts as that stage's first pulse.
- R9: `stage_o` stays in the range 0 to 5, and `stage_pulse_o` never has more than one bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear_i | input | 1 | Synchronous return to stage 0 with the counter at zero |
| pulse_i | input | 1 | Program pulse to route and count |
| limits_i | input | 48 | Per-stage two-digit BCD pulse limits, 8 bits per stage |
| last_stage_i | input | 3 | Index of the configured end stage |
| wrap_i | input | 1 | 1: wrap to stage 0 after the end stage; 0: hold on it |
| digit_valid_i | input | 1 | Direct digit select request |
| digit_i | input | 4 | Decimal digit for the computed jump |
| sign_valid_i | input | 1 | Sign branch request |
| sign_neg_i | input | 1 | Sign value, 1 means negative |
| stage_o | output | 3 | Current stage index |
| stage_pulse_o | output | 6 | Per-stage program output pulses |

## Verification
A wrong stage register shows at the ports on the very next routed pulse, as a bit of `stage_pulse_o` other than the one expected, and also at once on `stage_o`. A counter error stays hidden until the stage boundary. There it shows as an advance that comes one or more pulses too early or too late, so the bench runs every stage through its full limit, including a two-digit limit and a limit of 00. A wrong HOLD flag shows as a parked stepper that advances, or as a running stepper that stops; both are visible on the first pulse after the end stage completes.

// File: rtl/stepper_pkg.sv
package stepper_pkg;
    typedef enum logic [0:0] {
        ST_RUN  = 1'b0,
        ST_HOLD = 1'b1
    } step_state_e;

    localparam int unsigned BCD_W = 4;
endpackage

// File: rtl/step_bcd_counter.sv
module step_bcd_counter #(
    parameter  int unsigned NDIG = 2,
    localparam int unsigned W    = NDIG * stepper_pkg::BCD_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart_i,
    input  logic         inc_i,
    input  logic [W-1:0] limit_i,
    output logic         hit_o
);
    logic [W-1:0]    cnt_q;
    logic [W-1:0]    base;
    logic [W-1:0]    nxt;
    logic [NDIG-1:0] carry;

    // A restart in the same cycle as a count makes this pulse the first one.
    assign base     = restart_i ? '0 : cnt_q;
    assign carry[0] = 1'b1;

    for (genvar g = 0; g < NDIG; g++) begin : g_dig
        logic [3:0] d;
        assign d = base[g*4 +: 4];
        assign nxt[g*4 +: 4] = carry[g] ? ((d == 4'd9) ? 4'd0 : d + 4'd1) : d;
        if (g < NDIG - 1) begin : g_carry
            assign carry[g+1] = carry[g] && (d == 4'd9);
        end
    end

    assign hit_o = (limit_i == '0) || (nxt == limit_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (inc_i) begin
            cnt_q <= hit_o ? '0 : nxt;
        end else if (restart_i) begin
            cnt_q <= '0;
        end
    end
endmodule

// File: rtl/step_direct_decode.sv
module step_direct_decode #(
    parameter  int unsigned NSTAGE = 6,
    parameter  int unsigned DIG_W  = 4,
    localparam int unsigned SW     = $clog2(NSTAGE)
) (
    input  logic             digit_valid_i,
    input  logic [DIG_W-1:0] digit_i,
    input  logic             sign_valid_i,
    input  logic             sign_neg_i,
    output logic             sel_valid_o,
    output logic [SW-1:0]    sel_stage_o
);
    logic digit_ok;

    // Digits beyond the last stage index are dropped.
    assign digit_ok    = digit_valid_i && (digit_i < DIG_W'(NSTAGE));
    assign sel_valid_o = digit_ok || sign_valid_i;
    assign sel_stage_o = digit_ok   ? SW'(digit_i) :
                         sign_neg_i ? SW'(1)       : '0;
endmodule

// File: rtl/step_route.sv
module step_route #(
    parameter int unsigned NSTAGE = 6,
    parameter int unsigned SW     = 3
) (
    input  logic              pulse_i,
    input  logic [SW-1:0]     stage_i,
    output logic [NSTAGE-1:0] lines_o
);
    for (genvar g = 0; g < NSTAGE; g++) begin : g_line
        assign lines_o[g] = pulse_i && (stage_i == SW'(g));
    end
endmodule

// File: rtl/prog_stepper.sv
module prog_stepper
    import stepper_pkg::*;
#(
    parameter  int unsigned NUM_STAGES = 6,
    parameter  int unsigned CNT_DIGITS = 2,
    localparam int unsigned STAGE_W    = $clog2(NUM_STAGES),
    localparam int unsigned LIMIT_W    = CNT_DIGITS * BCD_W
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          clear_i,
    input  logic                          pulse_i,
    input  logic [NUM_STAGES*LIMIT_W-1:0] limits_i,
    input  logic [STAGE_W-1:0]            last_stage_i,
    input  logic                          wrap_i,
    input  logic                          digit_valid_i,
    input  logic [BCD_W-1:0]              digit_i,
    input  logic                          sign_valid_i,
    input  logic                          sign_neg_i,
    output logic [STAGE_W-1:0]            stage_o,
    output logic [NUM_STAGES-1:0]         stage_pulse_o
);
    step_state_e               state_q, state_d;
    logic [STAGE_W-1:0]        stage_q, stage_d;
    logic                      sel_valid;
    logic [STAGE_W-1:0]        sel_stage;
    logic [STAGE_W-1:0]        target;
    logic [LIMIT_W-1:0]        lim_sel;
    logic                      hit;
    logic                      counting;
    logic                      finish;
    logic                      is_end;
    logic [STAGE_W-1:0]        adv_stage;
    logic                      adv_hold;
    logic [NUM_STAGES-1:0]     lines;
    logic [NUM_STAGES-1:0]     pulses_q;

    step_direct_decode #(
        .NSTAGE (NUM_STAGES),
        .DIG_W  (BCD_W)
    ) u_decode (
        .digit_valid_i (digit_valid_i),
        .digit_i       (digit_i),
        .sign_valid_i  (sign_valid_i),
        .sign_neg_i    (sign_neg_i),
        .sel_valid_o   (sel_valid),
        .sel_stage_o   (sel_stage)
    );

    // Stage that owns this cycle's pulse.
    assign target   = sel_valid ? sel_stage : stage_q;
    assign lim_sel  = limits_i[target*LIMIT_W +: LIMIT_W];
    assign counting = pulse_i && !clear_i && (sel_valid || (state_q == ST_RUN));
    assign finish   = counting && hit;
    assign is_end   = (target == last_stage_i) || (target == STAGE_W'(NUM_STAGES - 1));

    always_comb begin
        if (!is_end) begin
            adv_stage = target + STAGE_W'(1);
            adv_hold  = 1'b0;
        end else if (wrap_i) begin
            adv_stage = '0;
            adv_hold  = 1'b0;
        end else begin
            adv_stage = target;
            adv_hold  = 1'b1;
        end
    end

    step_bcd_counter #(
        .NDIG (CNT_DIGITS)
    ) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (clear_i || sel_valid),
        .inc_i     (counting),
        .limit_i   (lim_sel),
        .hit_o     (hit)
    );

    step_route #(
        .NSTAGE (NUM_STAGES),
        .SW     (STAGE_W)
    ) u_route (
        .pulse_i (pulse_i && !clear_i),
        .stage_i (target),
        .lines_o (lines)
    );

    // Next state: RUN advances or wraps; HOLD waits for clear or select.
    always_comb begin
        state_d = state_q;
        stage_d = stage_q;
        if (clear_i) begin
            state_d = ST_RUN;
            stage_d = '0;
        end else begin
            unique case (state_q)
                ST_RUN: begin
                    stage_d = finish ? adv_stage : target;
                    state_d = (finish && adv_hold) ? ST_HOLD : ST_RUN;
                end
                ST_HOLD: begin
                    if (sel_valid) begin
                        stage_d = finish ? adv_stage : target;
                        state_d = (finish && adv_hold) ? ST_HOLD : ST_RUN;
                    end
                end
                default: begin
                    state_d = ST_RUN;
                    stage_d = '0;
                end
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            stage_q <= '0;
        end else begin
            state_q <= state_d;
            stage_q <= stage_d;
        end
    end

    // Output register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pulses_q <= '0;
        end else begin
            pulses_q <= lines;
        end
    end

    assign stage_o       = stage_q;
    assign stage_pulse_o = pulses_q;
endmodule

// File: rtl/prog_stepper_chk.sv
module prog_stepper_chk #(
    parameter int unsigned NUM_STAGES = 6,
    parameter int unsigned STAGE_W    = 3
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  clear_i,
    input logic                  pulse_i,
    input logic                  digit_valid_i,
    input logic [3:0]            digit_i,
    input logic                  sign_valid_i,
    input logic                  sign_neg_i,
    input logic [STAGE_W-1:0]    stage_o,
    input logic [NUM_STAGES-1:0] stage_pulse_o
);
    logic dig_ok;
    assign dig_ok = digit_valid_i && (digit_i < 4'(NUM_STAGES));

    assert_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(stage_pulse_o));

    assert_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stage_o < STAGE_W'(NUM_STAGES));

    assert_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (stage_o == '0) && (stage_pulse_o == '0));

    assert_one_out_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_i && !clear_i) |=> ($countones(stage_pulse_o) == 1));

    assert_no_out_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !pulse_i |=> (stage_pulse_o == '0));

    assert_select_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && dig_ok && !pulse_i) |=> (stage_o == STAGE_W'($past(digit_i))));

    assert_ignore_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && !pulse_i && !dig_ok && !sign_valid_i) |=> $stable(stage_o));

    assert_sign_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && !dig_ok && sign_valid_i && !pulse_i)
            |=> (stage_o == ($past(sign_neg_i) ? STAGE_W'(1) : STAGE_W'(0))));

    assert_coincide_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && dig_ok && pulse_i)
            |=> (stage_pulse_o == (NUM_STAGES'(1) << $past(digit_i))));
endmodule

bind prog_stepper prog_stepper_chk #(
    .NUM_STAGES (NUM_STAGES),
    .STAGE_W    (STAGE_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .clear_i       (clear_i),
    .pulse_i       (pulse_i),
    .digit_valid_i (digit_valid_i),
    .digit_i       (digit_i),
    .sign_valid_i  (sign_valid_i),
    .sign_neg_i    (sign_neg_i),
    .stage_o       (stage_o),
    .stage_pulse_o (stage_pulse_o)
);

// File: tb/test_prog_stepper.sv
`timescale 1ns/1ps
module test_prog_stepper;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clear_i = 1'b0;
    logic        pulse_i = 1'b0;
    logic [47:0] limits_i;
    logic [2:0]  last_stage_i = 3'd5;
    logic        wrap_i = 1'b1;
    logic        digit_valid_i = 1'b0;
    logic [3:0]  digit_i = 4'd0;
    logic        sign_valid_i = 1'b0;
    logic        sign_neg_i = 1'b0;
    logic [2:0]  stage_o;
    logic [5:0]  stage_pulse_o;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    typedef struct {
        logic [5:0] p;
        logic [2:0] s;
        string      tag;
    } exp_t;
    exp_t q[$];

    // Reference model state
    int lim_dec[6] = '{2, 3, 1, 12, 0, 1};
    int m_stage = 0;
    int m_cnt   = 0;
    bit m_hold  = 0;

    always #4 clk = ~clk;

    prog_stepper i_prog_stepper (
        .clk           (clk),
        .rst_n         (rst_n),
        .clear_i       (clear_i),
        .pulse_i       (pulse_i),
        .limits_i      (limits_i),
        .last_stage_i  (last_stage_i),
        .wrap_i        (wrap_i),
        .digit_valid_i (digit_valid_i),
        .digit_i       (digit_i),
        .sign_valid_i  (sign_valid_i),
        .sign_neg_i    (sign_neg_i),
        .stage_o       (stage_o),
        .stage_pulse_o (stage_pulse_o)
    );

    function automatic void build_limits();
        for (int k = 0; k < 6; k++)
            limits_i[k*8 +: 8] = {4'(lim_dec[k] / 10), 4'(lim_dec[k] % 10)};
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step(input bit p, input bit clr, input bit dv, input int dig,
                        input bit sv, input bit neg, input string tag);
        exp_t e;
        int   sel;
        int   eff;
        @(negedge clk);
        pulse_i       = p;
        clear_i       = clr;
        digit_valid_i = dv;
        digit_i       = 4'(dig);
        sign_valid_i  = sv;
        sign_neg_i    = neg;
        e.p = '0;
        if (clr) begin
            m_stage = 0; m_cnt = 0; m_hold = 0;
        end else begin
            sel = -1;
            if (dv && dig <= 5) sel = dig;
            else if (sv) sel = neg ? 1 : 0;
            if (sel >= 0) begin
                m_stage = sel; m_cnt = 0; m_hold = 0;
            end
            if (p) begin
                e.p = 6'(1) << m_stage;
                if (!m_hold) begin
                    eff = (lim_dec[m_stage] == 0) ? 1 : lim_dec[m_stage];
                    m_cnt++;
                    if (m_cnt >= eff) begin
                        m_cnt = 0;
                        if (m_stage == int'(last_stage_i) || m_stage == 5) begin
                            if (wrap_i) m_stage = 0;
                            else m_hold = 1;
                        end else begin
                            m_stage++;
                        end
                    end
                end
            end
        end
        e.s   = 3'(m_stage);
        e.tag = tag;
        q.push_back(e);
    endtask

    // Scoreboard monitor
    always @(posedge clk) begin
        #2;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            chk({e.tag, " pulses"}, int'(stage_pulse_o), int'(e.p));
            chk({e.tag, " stage"}, int'(stage_o), int'(e.s));
        end
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        build_limits();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 reset stage", int'(stage_o), 0);
        chk("R1 reset pulses", int'(stage_pulse_o), 0);

        // R2 R3 R4: full sequence with wrap, idle cycles between pulses
        for (int i = 0; i < 24; i++) begin
            step(1, 0, 0, 0, 0, 0, "R3");
            step(0, 0, 0, 0, 0, 0, "R2");
        end

        // R5 computed jump, R6 ignored digit, R8 coinciding pulse
        step(0, 0, 1, 3, 0, 0, "R5");
        step(1, 0, 0, 0, 0, 0, "R5");
        step(1, 0, 0, 0, 0, 0, "R5");
        step(0, 0, 1, 7, 0, 0, "R6");
        step(0, 0, 1, 9, 0, 0, "R6");
        step(1, 0, 1, 6, 0, 0, "R6");
        step(1, 0, 1, 5, 0, 0, "R8");
        step(1, 0, 1, 1, 0, 0, "R8");
        step(1, 0, 0, 0, 0, 0, "R8");

        // R7 sign branch and digit precedence
        step(0, 0, 0, 0, 1, 1, "R7");
        step(0, 0, 0, 0, 1, 0, "R7");
        step(0, 0, 1, 4, 1, 1, "R7");
        step(1, 0, 1, 8, 1, 1, "R7");

        // R1 clear mid-count, drops coinciding pulse
        step(1, 0, 0, 0, 0, 0, "R1");
        step(1, 1, 0, 0, 0, 0, "R1");
        step(1, 0, 0, 0, 0, 0, "R1");
        step(1, 0, 0, 0, 0, 0, "R1");

        // R4 hold at configured end stage
        @(negedge clk);
        wrap_i       = 1'b0;
        last_stage_i = 3'd2;
        step(0, 1, 0, 0, 0, 0, "R4");
        for (int i = 0; i < 10; i++) step(1, 0, 0, 0, 0, 0, "R4");
        step(0, 0, 1, 0, 0, 0, "R5");
        step(1, 0, 0, 0, 0, 0, "R5");

        // R3 limit 00 behaves as 1; R4 index 5 is always an end stage
        step(0, 0, 1, 4, 0, 0, "R3");
        for (int i = 0; i < 4; i++) step(1, 0, 0, 0, 0, 0, "R4");
        step(0, 0, 0, 0, 0, 0, "R4");
        step(0, 0, 0, 0, 0, 0, "R4");

        @(negedge clk);
        pulse_i = 0; clear_i = 0; digit_valid_i = 0; sign_valid_i = 0;
        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule